// File: doc/BRIEF.md
# Depth Differential Storage Scheme Selector

This block takes the differentials of one depth tile, already split into a vertical part and a horizontal part. Each part is one first-order differential and a set of second-order differentials. The block picks, for each part separately, the narrowest storage format that can hold every second-order differential. There are three formats: a single bit per value, a 2-bit DPCM code, or a 7-bit DPCM code. If a part cannot fit even the widest format, the tile is marked as one that cannot be compressed.

Next to the scheme codes, the block produces the reduced-width fields that a later packing stage stores. These are one narrowed first-order field and one narrowed field per second-order differential. The single-bit format stores each value after a +1 offset. That offset is made by inverting the least significant bit, so no adder is needed. The first-order field of a single-bit part is lowered by one to make up for it.

A downstream packer only accepts certain (vertical, horizontal) combinations. When a part comes out narrower than the combination allows, the vertical part is widened. All results are registered once, so they appear on the cycle after the input strobe, together with a valid flag.

Top module: `dcs_scheme_select`

## Requirements
- R1: While reset is held and after its release, before the first accepted input, all outputs are zero. This includes out_valid, both scheme codes, mode, incompressible and every field.
- R2: A part whose second-order differentials all lie in {-1, 0} gets scheme code 0, the single-bit format.
- R3: A part whose second-order differentials all lie in -2..1, with at least one outside {-1, 0}, gets scheme code 1, the 2-bit format.
- R4: A part whose second-order differentials all lie in -64..63, with at least one outside -2..1, gets scheme code 2, the 7-bit format.
- R5: If either part has its first-order differential or any second-order differential outside -64..63, the following happens. incompressible is 1, both scheme codes are 3, mode is 5 and every field is zero.
- R6: The pairs (vertical, horizontal) that can appear are (0,0), (1,0), (2,0), (2,1) and (2,2). When the horizontal part needs code 1 or 2, the vertical code is raised to 2.
- R7: mode is 0, 1, 2, 3 or 4 for the pairs (0,0), (1,0), (2,0), (2,1) and (2,2) in that order, and 5 for an incompressible tile.
- R8: Under code 0, each second-order field has bit 0 set to the inverse of the differential's LSB. A differential of -1 gives 0 and one of 0 gives 1. All higher field bits are zero.
- R9: Under code 1, each field holds the differential's low 2 bits with the upper bits zero. Under code 2, each field holds its low 7 bits. Element i occupies field bits [7i+6:7i].
- R10: The first-order field is the low 7 bits of (d1 - 1) under code 0, computed modulo 128. Under codes 1 and 2 it is the low 7 bits of d1.
- R11: out_valid is 1 exactly on the cycle after a cycle with in_valid high.
- R12: When in_valid is low, input changes have no effect. Scheme codes, mode, incompressible and fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input differentials are valid this cycle |
| v_d1 | input | 16 | Vertical first-order differential, two's complement |
| v_d2 | input | 128 | Vertical second-order differentials, 8 x 16 bits, element i at [16i+15:16i] |
| h_d1 | input | 16 | Horizontal first-order differential |
| h_d2 | input | 128 | Horizontal second-order differentials, same layout |
| out_valid | output | 1 | Results below are new this cycle |
| v_scheme | output | 2 | Vertical scheme code (0 single-bit, 1 two-bit, 2 seven-bit, 3 raw) |
| h_scheme | output | 2 | Horizontal scheme code |
| mode | output | 3 | Combined mode index |
| incompressible | output | 1 | Tile cannot be compressed |
| v_d1_f | output | 7 | Vertical first-order field |
| v_d2_f | output | 56 | Vertical second-order fields, 8 x 7 bits |
| h_d1_f | output | 7 | Horizontal first-order field |
| h_d2_f | output | 56 | Horizontal second-order fields |

## Verification
Some properties are checked by assertions on every cycle. These are the one-cycle valid timing, the hold of all results while no input is offered, and the legality of each emitted scheme pair. They also cover the all-zero raw result of an incompressible tile and the zero upper bits in single-bit and 2-bit fields. The assertions cannot show that the chosen format is the narrowest one, the exact field values, the d1 decrement with its wrap, or the widening of a vertical part. Only the bench's directed boundary values and random tiles, compared against its own model, show these.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   typedef enum logic [1:0] {
      SCH_ONE  = 2'd0,
      SCH_MID  = 2'd1,
      SCH_WIDE = 2'd2,
      SCH_RAW  = 2'd3
   } scheme_e;

   localparam logic [2:0] MODE_RAW = 3'd5;

   // Mode index of a legal (vertical, horizontal) pair.
   function automatic logic [2:0] pair_mode(input scheme_e v, input scheme_e h);
      logic [2:0] m;
      if (v == SCH_RAW || h == SCH_RAW) begin
         m = MODE_RAW;
      end else if (h == SCH_ONE) begin
         case (v)
            SCH_ONE: m = 3'd0;
            SCH_MID: m = 3'd1;
            default: m = 3'd2;
         endcase
      end else if (h == SCH_MID) begin
         m = 3'd3;
      end else begin
         m = 3'd4;
      end
      return m;
   endfunction

endpackage

// File: rtl/dcs_range_class.sv
module dcs_range_class
   import dcs_pkg::*;
#(
   parameter int DW     = 16,
   parameter int N_D2   = 8,
   parameter int MID_W  = 2,
   parameter int WIDE_W = 7
) (
   input  logic [DW-1:0]      d1,
   input  logic [N_D2*DW-1:0] d2,
   output scheme_e            raw_scheme,
   output logic               overflow
);

   localparam int MID_TOP  = DW - MID_W + 1;
   localparam int WIDE_TOP = DW - WIDE_W + 1;

   logic [N_D2-1:0] fit_one;
   logic [N_D2-1:0] fit_mid;
   logic [N_D2-1:0] fit_wide;
   logic            d1_fit;

   // A value fits W signed bits when its bits from W-1 up are all equal.
   for (genvar i = 0; i < N_D2; i++) begin : g_elem
      logic [DW-1:0]       e;
      logic [MID_TOP-1:0]  top_mid;
      logic [WIDE_TOP-1:0] top_wide;
      assign e           = d2[i*DW +: DW];
      assign top_mid     = e[DW-1:MID_W-1];
      assign top_wide    = e[DW-1:WIDE_W-1];
      assign fit_one[i]  = (&e) | ~(|e);
      assign fit_mid[i]  = (&top_mid) | ~(|top_mid);
      assign fit_wide[i] = (&top_wide) | ~(|top_wide);
   end

   logic [WIDE_TOP-1:0] d1_top;
   assign d1_top = d1[DW-1:WIDE_W-1];
   assign d1_fit = (&d1_top) | ~(|d1_top);

   always_comb begin
      overflow = ~(d1_fit & (&fit_wide));
      if (overflow)          raw_scheme = SCH_RAW;
      else if (&fit_one)     raw_scheme = SCH_ONE;
      else if (&fit_mid)     raw_scheme = SCH_MID;
      else                   raw_scheme = SCH_WIDE;
   end

endmodule

// File: rtl/dcs_pair_resolve.sv
module dcs_pair_resolve
   import dcs_pkg::*;
(
   input  scheme_e    v_raw,
   input  scheme_e    h_raw,
   input  logic       v_ovf,
   input  logic       h_ovf,
   output scheme_e    v_fin,
   output scheme_e    h_fin,
   output logic [2:0] mode,
   output logic       incomp
);

   always_comb begin
      incomp = v_ovf | h_ovf;
      if (incomp) begin
         v_fin = SCH_RAW;
         h_fin = SCH_RAW;
      end else begin
         h_fin = h_raw;
         // a horizontal part wider than one bit needs the widest vertical format
         v_fin = (h_raw != SCH_ONE) ? SCH_WIDE : v_raw;
      end
      mode = pair_mode(v_fin, h_fin);
   end

endmodule

// File: rtl/dcs_field_reduce.sv
module dcs_field_reduce
   import dcs_pkg::*;
#(
   parameter int DW     = 16,
   parameter int N_D2   = 8,
   parameter int MID_W  = 2,
   parameter int WIDE_W = 7
) (
   input  scheme_e                scheme,
   input  logic [DW-1:0]          d1,
   input  logic [N_D2*DW-1:0]     d2,
   output logic [WIDE_W-1:0]      d1_f,
   output logic [N_D2*WIDE_W-1:0] d2_f
);

   localparam logic [WIDE_W-1:0] ONE_W = WIDE_W'(1);

   for (genvar i = 0; i < N_D2; i++) begin : g_field
      logic [DW-1:0]     e;
      logic [WIDE_W-1:0] f;
      assign e = d2[i*DW +: DW];
      always_comb begin
         f = '0;
         case (scheme)
            SCH_ONE:  f[0]         = ~e[0];          // +1 offset on the LSB
            SCH_MID:  f[MID_W-1:0] = e[MID_W-1:0];
            SCH_WIDE: f            = e[WIDE_W-1:0];
            default:  f            = '0;
         endcase
      end
      assign d2_f[i*WIDE_W +: WIDE_W] = f;
   end

   always_comb begin
      case (scheme)
         SCH_ONE:          d1_f = d1[WIDE_W-1:0] - ONE_W;
         SCH_MID, SCH_WIDE: d1_f = d1[WIDE_W-1:0];
         default:          d1_f = '0;
      endcase
   end

endmodule

// File: rtl/dcs_scheme_select.sv
module dcs_scheme_select
   import dcs_pkg::*;
#(
   parameter int DW     = 16,
   parameter int N_D2   = 8,
   parameter int MID_W  = 2,
   parameter int WIDE_W = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [DW-1:0]           v_d1,
   input  logic [N_D2*DW-1:0]      v_d2,
   input  logic [DW-1:0]           h_d1,
   input  logic [N_D2*DW-1:0]      h_d2,
   output logic                    out_valid,
   output logic [1:0]              v_scheme,
   output logic [1:0]              h_scheme,
   output logic [2:0]              mode,
   output logic                    incompressible,
   output logic [WIDE_W-1:0]       v_d1_f,
   output logic [N_D2*WIDE_W-1:0]  v_d2_f,
   output logic [WIDE_W-1:0]       h_d1_f,
   output logic [N_D2*WIDE_W-1:0]  h_d2_f
);

   localparam int NPART = 2;   // index 0 vertical, 1 horizontal
   localparam int FW    = N_D2 * WIDE_W;

   if (N_D2 < 1) begin : g_bad_n
      $error("N_D2 must be at least 1");
   end
   if (MID_W < 2) begin : g_bad_mid
      $error("MID_W must be at least 2");
   end
   if (WIDE_W <= MID_W) begin : g_bad_wide
      $error("WIDE_W must exceed MID_W");
   end
   if (DW <= WIDE_W) begin : g_bad_dw
      $error("DW must exceed WIDE_W");
   end

   logic [DW-1:0]      p_d1   [NPART];
   logic [N_D2*DW-1:0] p_d2   [NPART];
   scheme_e            p_raw  [NPART];
   logic               p_ovf  [NPART];
   scheme_e            p_fin  [NPART];
   logic [WIDE_W-1:0]  p_d1f  [NPART];
   logic [FW-1:0]      p_d2f  [NPART];

   assign p_d1[0] = v_d1;
   assign p_d2[0] = v_d2;
   assign p_d1[1] = h_d1;
   assign p_d2[1] = h_d2;

   for (genvar p = 0; p < NPART; p++) begin : g_part
      dcs_range_class #(
         .DW(DW), .N_D2(N_D2), .MID_W(MID_W), .WIDE_W(WIDE_W)
      ) u_class (
         .d1         (p_d1[p]),
         .d2         (p_d2[p]),
         .raw_scheme (p_raw[p]),
         .overflow   (p_ovf[p])
      );

      dcs_field_reduce #(
         .DW(DW), .N_D2(N_D2), .MID_W(MID_W), .WIDE_W(WIDE_W)
      ) u_reduce (
         .scheme (p_fin[p]),
         .d1     (p_d1[p]),
         .d2     (p_d2[p]),
         .d1_f   (p_d1f[p]),
         .d2_f   (p_d2f[p])
      );
   end

   scheme_e    v_fin;
   scheme_e    h_fin;
   logic [2:0] mode_c;
   logic       incomp_c;

   dcs_pair_resolve u_pair (
      .v_raw  (p_raw[0]),
      .h_raw  (p_raw[1]),
      .v_ovf  (p_ovf[0]),
      .h_ovf  (p_ovf[1]),
      .v_fin  (v_fin),
      .h_fin  (h_fin),
      .mode   (mode_c),
      .incomp (incomp_c)
   );

   assign p_fin[0] = v_fin;
   assign p_fin[1] = h_fin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         v_scheme       <= '0;
         h_scheme       <= '0;
         mode           <= '0;
         incompressible <= 1'b0;
         v_d1_f         <= '0;
         v_d2_f         <= '0;
         h_d1_f         <= '0;
         h_d2_f         <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            v_scheme       <= v_fin;
            h_scheme       <= h_fin;
            mode           <= mode_c;
            incompressible <= incomp_c;
            v_d1_f         <= p_d1f[0];
            v_d2_f         <= p_d2f[0];
            h_d1_f         <= p_d1f[1];
            h_d2_f         <= p_d2f[1];
         end
      end
   end

endmodule

// File: rtl/dcs_scheme_select_chk.sv
module dcs_scheme_select_chk #(
   parameter int N_D2   = 8,
   parameter int MID_W  = 2,
   parameter int WIDE_W = 7
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   out_valid,
   input logic [1:0]             v_scheme,
   input logic [1:0]             h_scheme,
   input logic [2:0]             mode,
   input logic                   incompressible,
   input logic [N_D2*WIDE_W-1:0] v_d2_f,
   input logic [N_D2*WIDE_W-1:0] h_d2_f
);

   localparam int FW = N_D2 * WIDE_W;

   function automatic logic [FW-1:0] upper_mask(input int keep);
      logic [FW-1:0] m;
      m = '0;
      for (int i = 0; i < N_D2; i++)
         for (int b = 0; b < WIDE_W; b++)
            if (b >= keep) m[i*WIDE_W + b] = 1'b1;
      return m;
   endfunction

   localparam logic [FW-1:0] MASK_ONE = upper_mask(1);
   localparam logic [FW-1:0] MASK_MID = upper_mask(MID_W);

   assert_valid_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(v_scheme) && $stable(h_scheme) && $stable(mode) &&
                     $stable(incompressible) && $stable(v_d2_f) && $stable(h_d2_f)));

   assert_pair_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !incompressible) |->
         (v_scheme != 2'd3 && h_scheme != 2'd3 && (h_scheme == 2'd0 || v_scheme == 2'd2)));

   assert_raw_tile_R5: assert property (@(posedge clk) disable iff (!rst_n)
      incompressible |-> (v_scheme == 2'd3 && h_scheme == 2'd3 && mode == 3'd5 &&
                          v_d2_f == '0 && h_d2_f == '0));

   assert_one_bit_v_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && v_scheme == 2'd0) |-> ((v_d2_f & MASK_ONE) == '0));

   assert_one_bit_h_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && h_scheme == 2'd0) |-> ((h_d2_f & MASK_ONE) == '0));

   assert_mid_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && v_scheme == 2'd1) |-> ((v_d2_f & MASK_MID) == '0));

endmodule

bind dcs_scheme_select dcs_scheme_select_chk #(
   .N_D2(N_D2), .MID_W(MID_W), .WIDE_W(WIDE_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .out_valid      (out_valid),
   .v_scheme       (v_scheme),
   .h_scheme       (h_scheme),
   .mode           (mode),
   .incompressible (incompressible),
   .v_d2_f         (v_d2_f),
   .h_d2_f         (h_d2_f)
);

// File: tb/dcs_scheme_select_test.sv
`timescale 1ns/1ps
module dcs_scheme_select_test;

   localparam int DW = 16;
   localparam int N  = 8;
   localparam int WW = 7;
   localparam int FW = N * WW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] v_d1 = '0, h_d1 = '0;
   logic [N*DW-1:0] v_d2 = '0, h_d2 = '0;
   logic          out_valid;
   logic [1:0]    v_scheme, h_scheme;
   logic [2:0]    mode;
   logic          incompressible;
   logic [WW-1:0] v_d1_f, h_d1_f;
   logic [FW-1:0] v_d2_f, h_d2_f;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   dcs_scheme_select uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .v_d1(v_d1), .v_d2(v_d2), .h_d1(h_d1), .h_d2(h_d2),
      .out_valid(out_valid), .v_scheme(v_scheme), .h_scheme(h_scheme),
      .mode(mode), .incompressible(incompressible),
      .v_d1_f(v_d1_f), .v_d2_f(v_d2_f), .h_d1_f(h_d1_f), .h_d2_f(h_d2_f)
   );

   task automatic check(input string req, input string what,
                        input logic [FW-1:0] act, input logic [FW-1:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int elem(input logic [N*DW-1:0] d2, input int i);
      return int'($signed(d2[i*DW +: DW]));
   endfunction

   // 0 one-bit, 1 two-bit, 2 seven-bit, 3 out of range
   function automatic int raw_class(input logic [DW-1:0] d1, input logic [N*DW-1:0] d2);
      int  x;
      bit  one = 1, mid = 1, wide = 1;
      x = int'($signed(d1));
      if (x < -64 || x > 63) return 3;
      for (int i = 0; i < N; i++) begin
         x = elem(d2, i);
         if (!(x == -1 || x == 0)) one = 0;
         if (x < -2 || x > 1) mid = 0;
         if (x < -64 || x > 63) wide = 0;
      end
      if (!wide) return 3;
      if (one) return 0;
      if (mid) return 1;
      return 2;
   endfunction

   function automatic logic [FW-1:0] exp_fields(input int s, input logic [N*DW-1:0] d2);
      logic [FW-1:0] r = '0;
      int x;
      for (int i = 0; i < N; i++) begin
         x = elem(d2, i);
         case (s)
            0: r[i*WW +: WW] = (x == -1) ? 7'd0 : 7'd1;
            1: r[i*WW +: WW] = 7'(x & 3);
            2: r[i*WW +: WW] = 7'(x & 127);
            default: r[i*WW +: WW] = 7'd0;
         endcase
      end
      return r;
   endfunction

   function automatic logic [WW-1:0] exp_d1(input int s, input logic [DW-1:0] d1);
      int x = int'($signed(d1));
      if (s == 0) return 7'((x - 1) & 127);
      if (s == 3) return 7'd0;
      return 7'(x & 127);
   endfunction

   function automatic logic [N*DW-1:0] fill(input int v);
      logic [N*DW-1:0] r;
      for (int i = 0; i < N; i++) r[i*DW +: DW] = 16'(v);
      return r;
   endfunction

   task automatic apply(input logic [DW-1:0] vd1, input logic [N*DW-1:0] vd2,
                        input logic [DW-1:0] hd1, input logic [N*DW-1:0] hd2);
      int vr, hr, vs, hs, em;
      logic ic;
      logic [WW-1:0] ev1, eh1;
      logic [FW-1:0] ev2, eh2;
      vr = raw_class(vd1, vd2);
      hr = raw_class(hd1, hd2);
      ic = (vr == 3 || hr == 3);
      if (ic) begin vs = 3; hs = 3; em = 5; end
      else begin
         hs = hr;
         vs = (hr != 0) ? 2 : vr;                     // R6 widening
         if (hs == 0) em = vs;                        // R7 table
         else if (hs == 1) em = 3;
         else em = 4;
      end
      ev1 = exp_d1(vs, vd1); eh1 = exp_d1(hs, hd1);
      ev2 = exp_fields(vs, vd2); eh2 = exp_fields(hs, hd2);

      @(negedge clk);
      v_d1 = vd1; v_d2 = vd2; h_d1 = hd1; h_d2 = hd2; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R11", "out_valid", FW'(out_valid), FW'(1));
      check("R2/R3/R4/R6", "v_scheme", FW'(v_scheme), FW'(vs));
      check("R2/R3/R4/R6", "h_scheme", FW'(h_scheme), FW'(hs));
      check("R7", "mode", FW'(mode), FW'(em));
      check("R5", "incompressible", FW'(incompressible), FW'(ic));
      check("R8/R9", "v_d2_f", v_d2_f, ev2);
      check("R8/R9", "h_d2_f", h_d2_f, eh2);
      check("R10", "v_d1_f", FW'(v_d1_f), FW'(ev1));
      check("R10", "h_d1_f", FW'(h_d1_f), FW'(eh1));

      // R12: new inputs without in_valid must leave the results untouched
      v_d2 = fill(100); h_d2 = fill(-3); v_d1 = 16'd999; h_d1 = 16'd0;
      @(negedge clk);
      check("R11", "out_valid low", FW'(out_valid), FW'(0));
      check("R12", "hold mode", FW'(mode), FW'(em));
      check("R12", "hold v_d2_f", v_d2_f, ev2);
      check("R12", "hold h_scheme", FW'(h_scheme), FW'(hs));
   endtask

   task automatic gen_part(input int cls, output logic [DW-1:0] d1,
                           output logic [N*DW-1:0] d2);
      int lo, hi;
      case (cls)
         0: begin lo = -1;  hi = 0;  end
         1: begin lo = -2;  hi = 1;  end
         default: begin lo = -64; hi = 63; end
      endcase
      for (int i = 0; i < N; i++)
         d2[i*DW +: DW] = 16'(lo + int'($urandom_range(hi - lo, 0)));
      d1 = 16'(int'($urandom_range(127, 0)) - 64);
      if (cls == 3) d2[$urandom_range(N-1, 0)*DW +: DW] =
                       ($urandom_range(1, 0) != 0) ? 16'd64 : 16'(-65);
      if (cls == 4) d1 = ($urandom_range(1, 0) != 0) ? 16'd300 : 16'(-65);
   endtask

   initial begin
      logic [N*DW-1:0] a, b;
      logic [DW-1:0]   a1, b1;
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "out_valid in reset", FW'(out_valid), FW'(0));
      check("R1", "fields in reset", v_d2_f | h_d2_f, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "codes after reset", FW'({v_scheme, h_scheme, mode, incompressible}), FW'(0));
      check("R1", "d1 fields after reset", FW'({v_d1_f, h_d1_f}), FW'(0));

      // directed corner cases
      apply(16'd5, fill(0), 16'(-3), fill(-1));                 // R2 both one-bit
      a = fill(-2); a[3*DW +: DW] = 16'd1;
      apply(16'd0, a, 16'd4, fill(0));                          // R3 v two-bit
      a = fill(63); a[1*DW +: DW] = 16'(-64);
      apply(16'(-64), a, 16'd63, fill(-1));                     // R4 boundaries
      apply(16'd2, fill(0), 16'd1, fill(1));                    // R6 widen one-bit v
      apply(16'd2, fill(1), 16'd1, fill(-7));                   // R6 widen two-bit v
      a = fill(0); a[7*DW +: DW] = 16'd64;
      apply(16'd1, a, 16'd1, fill(0));                          // R5 element overflow
      apply(16'd1, fill(0), 16'(-65), fill(0));                 // R5 d1 overflow
      apply(16'(-64), fill(-1), 16'd0, fill(0));                // R10 decrement wraps

      // random tiles
      for (int t = 0; t < 400; t++) begin
         gen_part($urandom_range(4, 0), a1, a);
         gen_part($urandom_range(4, 0), b1, b);
         apply(a1, a, b1, b);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule